// File: doc/BRIEF.md
# Remote Page Placement Advisor

This block watches the cache misses that processing nodes take on memory pages homed on some other node, and turns that traffic into page placement advice. Each miss report names a page and the node that missed on it, together with the page's home node. Reports where the requester is the home node are local and are thrown away. Remote reports feed a small fully associative table that keeps, for each tracked page, one saturating miss counter per node.

When a report lifts a page's total remote miss count to or above a programmable threshold, the block looks at how those misses are spread across the nodes. If the busiest node holds at least a programmable fraction of the total, it advises moving the page to that node. Otherwise it advises keeping a copy of the page on each sharing node. The advice carries only a page number and a node number, since placement is a per-page decision and cache-block coherence is handled elsewhere. Once the advice is taken from the output, the page's counters restart from zero. The actual copying, remapping and coherence work is done by other logic.

Miss reports come in over a valid/ready handshake and advice leaves over another one. A small write port sets the threshold and the dominance fraction.

Top module: `page_place_advisor`

## Requirements
- R1: After reset no advice is offered, `reqReady` is 1, the threshold is 16 and the dominance numerator is 12 (that is, 12/16).
- R2: A report whose `reqNode` equals `reqHome` is accepted and changes no counter, so it can never cause advice.
- R3: Each remote report adds one to the counter of its page and requesting node; the counters are 8 bits wide and stick at 255, and the page total is the sum of its node counters.
- R4: When an accepted remote report brings its page's total to a value greater than or equal to the threshold, advice for that page appears on the output in the cycle after the accepting clock edge, with `recPage` equal to the page number.
- R5: Advice is a move (`recReplicate` = 0) when the largest node count times 16 is greater than or equal to the numerator times the page total; `recNode` is the node with the largest count, the lowest node number winning a tie.
- R6: When the condition of R5 fails, the advice is to replicate (`recReplicate` = 1).
- R7: In the clock edge where advice is taken (`recValid` and `recReady` both 1), all counters of the advised page return to zero; a report to that page in the same cycle counts from zero.
- R8: While advice for a page waits on the output, further reports to that page are accepted and counted but raise no second advice; at most one page is waiting at any time.
- R9: While advice waits and `recReady` is 0, the advice fields hold still, and a report that would raise advice for another page is held with `reqReady` at 0 until the output frees.
- R10: A report to a page not in the table (16 entries) takes over the entry with the lowest total among entries not waiting on the output, the lowest entry number winning a tie; unused entries count as total 0.
- R11: A write with `cfgSel` = 0 loads the threshold from `cfgWdata`; a write with `cfgSel` = 1 loads the dominance numerator from `cfgWdata[3:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Miss report present |
| reqReady | output | 1 | Miss report taken this cycle |
| reqPage | input | 20 | Page number of the miss |
| reqNode | input | 2 | Node that missed |
| reqHome | input | 2 | Home node of the page |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0: threshold, 1: dominance numerator |
| cfgWdata | input | 10 | Configuration write value |
| recValid | output | 1 | Advice present |
| recReady | input | 1 | Advice taken this cycle |
| recPage | output | 20 | Page the advice is for |
| recNode | output | 2 | Target node for a move (busiest node) |
| recReplicate | output | 1 | 1: replicate, 0: move to recNode |

## Verification
Directed runs feed a page misses from one node only, from two nodes in a tie, and from two nodes either side of the default 12/16 split, which separates the move decision, the replicate decision and the tie rule. A long run of reports from one node past 255 separates a saturating counter from a wrapping one, and filling all sixteen entries with distinct totals before a new page arrives shows which entry is given up. Holding `recReady` low while reports arrive for the waiting page and for a second page tells suppression apart from stalling. A seeded random phase mixes local and remote reports over more pages than the table holds, with random output back-pressure and mid-run configuration writes, against a cycle model kept in the bench.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  // Strobes raised by the control for the datapath in one cycle
  typedef struct packed {
    logic update;  // accepted remote report: write the selected entry
    logic load;    // accepted report crosses threshold: capture advice
  } advStrobe_t;
endpackage

// File: rtl/ppa_control.sv
module ppa_control
  import ppa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       remote,
  input  logic       crossNew,
  input  logic       recReady,
  output logic       reqReady,
  output logic       recValid,
  output advStrobe_t stb
);
  logic recValidQ;
  logic slotFree;

  assign slotFree   = !recValidQ || recReady;
  assign reqReady   = !crossNew || slotFree;
  assign stb.update = reqValid && reqReady && remote;
  assign stb.load   = reqValid && reqReady && remote && crossNew;
  assign recValid   = recValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) recValidQ <= 1'b0;
    else if (stb.load) recValidQ <= 1'b1;
    else if (recValidQ && recReady) recValidQ <= 1'b0;
  end

  // R9: advice stays offered until taken
  assert_rec_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (recValidQ && !recReady) |=> recValidQ);
  // R4: a captured advice is visible the next cycle
  assert_load_shows_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> recValidQ);
endmodule

// File: rtl/ppa_datapath.sv
module ppa_datapath
  import ppa_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_NODES   = 4,
  parameter int CNT_W       = 8,
  parameter int PAGE_W      = 20,
  parameter int THR_RESET   = 16,
  parameter int RATIO_RESET = 12,
  localparam int NODE_W     = $clog2(NUM_NODES),
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int TOT_W      = CNT_W + $clog2(NUM_NODES),
  localparam int RATIO_W    = 4,
  localparam int PROD_W     = TOT_W + RATIO_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  advStrobe_t        stb,
  input  logic              reqValid,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [NODE_W-1:0] reqHome,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [TOT_W-1:0]  cfgWdata,
  input  logic              recValid,
  input  logic              recReady,
  output logic              remote,
  output logic              crossNew,
  output logic [PAGE_W-1:0] recPage,
  output logic [NODE_W-1:0] recNode,
  output logic              recReplicate
);
  logic [NUM_ENTRIES-1:0]                          vldQ, pendQ;
  logic [NUM_ENTRIES-1:0][PAGE_W-1:0]              pageQ;
  logic [NUM_ENTRIES-1:0][NUM_NODES-1:0][CNT_W-1:0] cntQ;
  logic [TOT_W-1:0]   thrQ;
  logic [RATIO_W-1:0] ratioQ;
  logic [PAGE_W-1:0]  recPageQ;
  logic [NODE_W-1:0]  recNodeQ;
  logic               recReplQ;

  // View of the table after a drain in this cycle
  logic drainNow;
  logic [NUM_ENTRIES-1:0]                          effPend;
  logic [NUM_ENTRIES-1:0][NUM_NODES-1:0][CNT_W-1:0] effCnt;
  logic [NUM_ENTRIES-1:0][TOT_W-1:0]               effTot;

  logic                              hit, vicFound, selPend, dominant;
  logic [IDX_W-1:0]                  hitIdx, vicIdx, selIdx;
  logic [TOT_W-1:0]                  vicTot, newTot;
  logic [NUM_NODES-1:0][CNT_W-1:0]   newCnt;
  logic [NODE_W-1:0]                 topNode;
  logic [CNT_W-1:0]                  topCnt;

  assign drainNow = recValid && recReady;
  assign remote   = reqNode != reqHome;

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      effPend[i] = pendQ[i] && !drainNow;
      effTot[i]  = '0;
      for (int n = 0; n < NUM_NODES; n++) begin
        effCnt[i][n] = (pendQ[i] && drainNow) ? '0 : cntQ[i][n];
        effTot[i]    = effTot[i] + TOT_W'(effCnt[i][n]);
      end
    end
  end

  // Associative lookup and victim choice
  always_comb begin
    hit = 1'b0; hitIdx = '0;
    vicFound = 1'b0; vicIdx = '0; vicTot = '1;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!hit && vldQ[i] && pageQ[i] == reqPage) begin
        hit = 1'b1; hitIdx = IDX_W'(i);
      end
      if (!effPend[i] && (!vicFound || effTot[i] < vicTot)) begin
        vicFound = 1'b1; vicIdx = IDX_W'(i); vicTot = effTot[i];
      end
    end
    selIdx  = hit ? hitIdx : vicIdx;
    selPend = hit && effPend[hitIdx];
  end

  // Counter update, total, busiest node and dominance test
  always_comb begin
    newCnt = hit ? effCnt[hitIdx] : '0;
    if (newCnt[reqNode] != '1) newCnt[reqNode] = newCnt[reqNode] + 1'b1;
    newTot = '0; topNode = '0; topCnt = '0;
    for (int n = 0; n < NUM_NODES; n++) begin
      newTot = newTot + TOT_W'(newCnt[n]);
      if (newCnt[n] > topCnt) begin
        topCnt = newCnt[n]; topNode = NODE_W'(n);
      end
    end
    dominant = (PROD_W'(topCnt) << RATIO_W) >= (PROD_W'(ratioQ) * PROD_W'(newTot));
    crossNew = reqValid && remote && !selPend && (newTot >= thrQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vldQ <= '0; pendQ <= '0; pageQ <= '0; cntQ <= '0;
      thrQ <= TOT_W'(THR_RESET); ratioQ <= RATIO_W'(RATIO_RESET);
      recPageQ <= '0; recNodeQ <= '0; recReplQ <= 1'b0;
    end else begin
      if (cfgWe) begin
        if (cfgSel) ratioQ <= cfgWdata[RATIO_W-1:0];
        else        thrQ   <= cfgWdata;
      end
      if (drainNow) begin
        for (int i = 0; i < NUM_ENTRIES; i++)
          if (pendQ[i]) cntQ[i] <= '0;
        pendQ <= '0;
      end
      if (stb.update) begin
        vldQ[selIdx]  <= 1'b1;
        pageQ[selIdx] <= reqPage;
        cntQ[selIdx]  <= newCnt;
        pendQ[selIdx] <= stb.load || selPend;
      end
      if (stb.load) begin
        recPageQ <= reqPage;
        recNodeQ <= topNode;
        recReplQ <= !dominant;
      end
    end
  end

  assign recPage      = recPageQ;
  assign recNode      = recNodeQ;
  assign recReplicate = recReplQ;

  // R8: one waiting page at most, and only while advice is offered
  assert_one_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(pendQ) <= 1) && ((|pendQ) == recValid));
  // R2: a local report leaves every counter untouched
  assert_local_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !remote && !drainNow) |=> $stable(cntQ));
  // R9: advice fields hold while the output is stalled
  assert_payload_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && !recReady) |=> $stable({recPageQ, recNodeQ, recReplQ}));
endmodule

// File: rtl/page_place_advisor.sv
module page_place_advisor
  import ppa_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int NUM_NODES   = 4,
  parameter int CNT_W       = 8,
  parameter int PAGE_W      = 20,
  parameter int THR_RESET   = 16,
  parameter int RATIO_RESET = 12,
  localparam int NODE_W     = $clog2(NUM_NODES),
  localparam int TOT_W      = CNT_W + $clog2(NUM_NODES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [NODE_W-1:0] reqNode,
  input  logic [NODE_W-1:0] reqHome,
  input  logic              cfgWe,
  input  logic              cfgSel,
  input  logic [TOT_W-1:0]  cfgWdata,
  output logic              recValid,
  input  logic              recReady,
  output logic [PAGE_W-1:0] recPage,
  output logic [NODE_W-1:0] recNode,
  output logic              recReplicate
);
  advStrobe_t stb;
  logic remote, crossNew;

  ppa_control u_ctrl (
    .clk, .rstN, .reqValid, .remote, .crossNew, .recReady,
    .reqReady, .recValid, .stb
  );

  ppa_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES), .NUM_NODES(NUM_NODES), .CNT_W(CNT_W),
    .PAGE_W(PAGE_W), .THR_RESET(THR_RESET), .RATIO_RESET(RATIO_RESET)
  ) u_dp (
    .clk, .rstN, .stb, .reqValid, .reqPage, .reqNode, .reqHome,
    .cfgWe, .cfgSel, .cfgWdata, .recValid, .recReady,
    .remote, .crossNew, .recPage, .recNode, .recReplicate
  );
endmodule

// File: tb/sim_page_place_advisor.sv
`timescale 1ns/1ps
module sim_page_place_advisor;
  localparam int N = 16;
  localparam int M = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [19:0] reqPage = '0;
  logic [1:0] reqNode = '0, reqHome = '0;
  logic cfgWe = 1'b0, cfgSel = 1'b0;
  logic [9:0] cfgWdata = '0;
  logic recValid, recReady = 1'b1;
  logic [19:0] recPage;
  logic [1:0] recNode;
  logic recReplicate;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  page_place_advisor u0 (
    .clk, .rstN, .reqValid, .reqReady, .reqPage, .reqNode, .reqHome,
    .cfgWe, .cfgSel, .cfgWdata, .recValid, .recReady, .recPage, .recNode,
    .recReplicate
  );

  // ---------------- bench model built from the requirements ----------------
  int  mCnt[N][M];
  int  mPage[N];
  bit  mVld[N], mPend[N];
  int  mThr, mRatio;
  bit  mRecV, mRecRepl;
  int  mRecPage, mRecNode;
  // results of predict
  bit  pReady, pCross, pRemote, pSelPend, pDom, pDrain;
  int  pSel, pTop, pTot;
  int  pNew[M];

  function automatic int effc(int i, int n, bit drn);
    return (drn && mPend[i]) ? 0 : mCnt[i][n];
  endfunction

  task automatic predict();
    bit hit = 0; int hitIdx = 0; int vic = -1; int vicTot = 0; int topC = 0;
    pDrain  = mRecV && recReady;
    pRemote = (reqNode != reqHome);
    for (int i = 0; i < N; i++)
      if (!hit && mVld[i] && mPage[i] == int'(reqPage)) begin hit = 1; hitIdx = i; end
    for (int i = 0; i < N; i++) begin
      int t = 0;
      for (int n = 0; n < M; n++) t += effc(i, n, pDrain);
      if (!(mPend[i] && !pDrain) && (vic < 0 || t < vicTot)) begin vic = i; vicTot = t; end
    end
    pSel = hit ? hitIdx : vic;
    pSelPend = hit && mPend[hitIdx] && !pDrain;
    for (int n = 0; n < M; n++) pNew[n] = hit ? effc(hitIdx, n, pDrain) : 0;
    if (pNew[reqNode] < 255) pNew[reqNode]++;
    pTot = 0; pTop = 0;
    for (int n = 0; n < M; n++) begin
      pTot += pNew[n];
      if (pNew[n] > topC) begin topC = pNew[n]; pTop = n; end
    end
    pDom   = (topC * 16) >= (mRatio * pTot);
    pCross = reqValid && pRemote && !pSelPend && (pTot >= mThr);
    pReady = !pCross || !mRecV || recReady;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mThr = 16; mRatio = 12; mRecV = 0; mRecRepl = 0; mRecPage = 0; mRecNode = 0;
      for (int i = 0; i < N; i++) begin
        mVld[i] = 0; mPend[i] = 0; mPage[i] = 0;
        for (int n = 0; n < M; n++) mCnt[i][n] = 0;
      end
    end else begin
      predict();
      if (pDrain)
        for (int i = 0; i < N; i++)
          if (mPend[i]) begin
            mPend[i] = 0;
            for (int n = 0; n < M; n++) mCnt[i][n] = 0;
          end
      if (reqValid && pReady && pRemote) begin
        mVld[pSel] = 1; mPage[pSel] = int'(reqPage);
        for (int n = 0; n < M; n++) mCnt[pSel][n] = pNew[n];
        mPend[pSel] = pCross || pSelPend;
        if (pCross) begin
          mRecV = 1; mRecPage = int'(reqPage); mRecNode = pTop; mRecRepl = !pDom;
        end else if (pDrain) mRecV = 0;
      end else if (pDrain) mRecV = 0;
      if (cfgWe) begin
        if (cfgSel) mRatio = int'(cfgWdata) & 15;
        else        mThr   = int'(cfgWdata);
      end
    end
  end

  task automatic chk(string tag, bit ok, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      predict();
      chk("R9 reqReady", reqReady == pReady, int'(reqReady), int'(pReady));
      chk("R4 recValid", recValid == mRecV, int'(recValid), int'(mRecV));
      if (recValid && mRecV) begin
        chk("R4 recPage", int'(recPage) == mRecPage, int'(recPage), mRecPage);
        chk("R5 recNode", int'(recNode) == mRecNode, int'(recNode), mRecNode);
        chk("R6 recReplicate", recReplicate == mRecRepl, int'(recReplicate), int'(mRecRepl));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send(int page, int node, int home);
    @(posedge clk); #1;
    reqValid = 1'b1; reqPage = 20'(page); reqNode = 2'(node); reqHome = 2'(home);
    do @(negedge clk); while (!reqReady);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic sendN(int k, int page, int node, int home);
    for (int j = 0; j < k; j++) send(page, node, home);
  endtask

  task automatic setCfg(bit sel, int val);
    @(posedge clk); #1;
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = 10'(val);
    @(posedge clk); #1;
    cfgWe = 1'b0;
  endtask

  // call right after send: output of the last accepted report
  task automatic expectRec(string tag, int page, int node, bit repl);
    @(negedge clk);
    chk(tag, recValid == 1'b1, int'(recValid), 1);
    chk(tag, int'(recPage) == page, int'(recPage), page);
    if (!repl) chk(tag, int'(recNode) == node, int'(recNode), node);
    chk(tag, recReplicate == repl, int'(recReplicate), int'(repl));
  endtask

  task automatic expectNone(string tag);
    @(negedge clk);
    chk(tag, recValid == 1'b0, int'(recValid), 0);
  endtask

  task automatic doReset();
    @(posedge clk); #1; rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset recValid", recValid == 1'b0, int'(recValid), 0);
    chk("R1 reset reqReady", reqReady == 1'b1, int'(reqReady), 1);

    // R1 default threshold 16 and numerator 12
    sendN(15, 'h00A0, 1, 0); expectNone("R1 below default threshold");
    send('h00A0, 1, 0);      expectRec("R1 default threshold", 'h00A0, 1, 0);
    sendN(11, 'h00B0, 1, 0); sendN(4, 'h00B0, 2, 0);
    send('h00B0, 2, 0);      expectRec("R1 default ratio 11/16 replicates", 'h00B0, 0, 1);
    sendN(12, 'h00C0, 1, 0); sendN(3, 'h00C0, 2, 0);
    send('h00C0, 2, 0);      expectRec("R5 12/16 moves", 'h00C0, 1, 0);

    // R11 threshold 4, R4 move to single user
    setCfg(0, 4);
    sendN(3, 'h0100, 1, 0); expectNone("R11 threshold 4 not reached");
    send('h0100, 1, 0);     expectRec("R4 crossing at 4", 'h0100, 1, 0);

    // R2 local reports ignored
    sendN(10, 'h0200, 2, 2); expectNone("R2 local reports dropped");
    sendN(3, 'h0200, 3, 2);  expectNone("R2 only remote counted");
    send('h0200, 3, 2);      expectRec("R2 remote crossing", 'h0200, 3, 0);

    // R6 replicate on even split, R5 tie to lowest node with numerator 8
    send('h0300, 1, 0); send('h0300, 2, 0); send('h0300, 1, 0);
    send('h0300, 2, 0); expectRec("R6 even split replicates", 'h0300, 0, 1);
    setCfg(1, 8);
    send('h0310, 2, 0); send('h0310, 1, 0); send('h0310, 2, 0);
    send('h0310, 1, 0); expectRec("R5 tie moves to lowest node", 'h0310, 1, 0);
    setCfg(1, 12);

    // R7 counters restart after advice taken
    sendN(3, 'h0300, 1, 0); expectNone("R7 counters cleared");
    send('h0300, 1, 0);     expectRec("R7 recount from zero", 'h0300, 1, 0);

    // R8 / R9 stalled output
    @(posedge clk); #1 recReady = 1'b0;
    sendN(4, 'h0400, 1, 0);
    expectRec("R8 first advice", 'h0400, 1, 0);
    sendN(5, 'h0400, 1, 0);
    expectRec("R8 no second advice for waiting page", 'h0400, 1, 0);
    sendN(3, 'h0500, 2, 0);
    @(posedge clk); #1;
    reqValid = 1'b1; reqPage = 20'h0500; reqNode = 2'd2; reqHome = 2'd0;
    @(negedge clk);
    chk("R9 crossing held", reqReady == 1'b0, int'(reqReady), 0);
    @(negedge clk);
    chk("R9 still held", reqReady == 1'b0, int'(reqReady), 0);
    chk("R9 payload stable", int'(recPage) == 'h0400, int'(recPage), 'h0400);
    recReady = 1'b1;
    @(posedge clk); #1 reqValid = 1'b0;
    @(negedge clk);
    chk("R9 released advice", int'(recPage) == 'h0500 && recValid,
        int'(recPage), 'h0500);
    sendN(3, 'h0400, 1, 0); expectNone("R7 waiting page cleared on take");

    // R10 replacement, then R3 saturation
    doReset();
    setCfg(0, 200);
    for (int p = 0; p < N; p++) sendN(p + 1, 'h1000 + p, 1, 0);
    send('h2000, 1, 0);       // evicts page 0x1000 (total 1)
    setCfg(0, 3);
    send('h1000, 1, 0); send('h1000, 1, 0);
    expectNone("R10 lowest-total entry was evicted");
    send('h1001, 1, 0);       expectRec("R10 second entry kept", 'h1001, 1, 0);
    setCfg(0, 300);
    sendN(300, 'h3000, 2, 0); expectNone("R3 saturates at 255");
    sendN(44, 'h3000, 3, 0);  expectNone("R3 total 299");
    send('h3000, 3, 0);       expectRec("R3 total 300 crosses", 'h3000, 2, 0);

    // random phase
    doReset();
    setCfg(0, 2 + ($urandom % 10));
    for (int c = 0; c < 4000; c++) begin
      @(posedge clk); #1;
      reqValid = ($urandom % 4) != 0;
      reqPage  = 20'('h4000 + ($urandom % 24));
      reqNode  = 2'($urandom % 4);
      reqHome  = 2'($urandom % 4);
      recReady = ($urandom % 10) < 7;
      cfgWe    = ($urandom % 200) == 0;
      cfgSel   = $urandom % 2;
      cfgWdata = cfgSel ? 10'($urandom % 16) : 10'(2 + ($urandom % 12));
    end
    @(posedge clk); #1;
    reqValid = 1'b0; cfgWe = 1'b0; recReady = 1'b1;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule